// File: doc/BRIEF.md
# Trace Unit Programming Control

This block is the register front end that software uses to bring an instruction trace unit up and down. It sits on a simple 32-bit register bus with single-cycle accesses and registered read data. It holds an OS lock that guards the trace registers, a unit enable bit and a power-up request bit. It reports an idle flag that tells software when the unit has settled. It also keeps a small bank of trace configuration registers and a read-only capability word.

Software first writes the lock register with any value to open access. It then clears the enable bit and polls the status register until idle is set. Only then is the configuration written. Software next sets the power-up request, sets the enable bit and polls until idle drops. The idle flag follows a change of the enable bit after a configurable number of clock cycles, which stands for the unit draining or starting up. The block refuses configuration writes while the unit is running or still draining, so a configuration never changes under a live trace.

Top module: `trace_prog_ctrl`

## Requirements
- R1: A synchronous active-low reset sets the OS lock, clears enable and power-up request, forces idle to 1, clears the configuration registers and the read data.
- R2: A write of any data value to word address 0 (lock register) clears the OS lock. Reading address 0 returns the lock state in bit 0, and the status register at address 2 returns idle in bit 0 and the lock state in bit 1.
- R3: While the OS lock is set, writes to the enable register, the power register and the configuration registers have no effect.
- R4: Bit 0 of the enable register at word address 1 is the unit enable; a write that is accepted drives `enOut` from the clock edge of the write.
- R5: When the enable bit goes from 1 to 0, idle rises exactly IDLE_LAT clock edges after the edge of the write.
- R6: When the enable bit goes from 0 to 1, idle falls exactly IDLE_LAT clock edges after the edge of the write.
- R7: A write to a configuration register (word addresses CFG_BASE to CFG_BASE+NUM_CFG-1, default 8 to 11) is stored only if the unit is unlocked, disabled and idle; a write while enabled or still draining is dropped.
- R8: A read of a configuration register returns zero while the OS lock is set or the unit is enabled; otherwise it returns the stored value.
- R9: Bit 0 of the power register at word address 3 is the power-up request and drives `pwrUpOut`; software can set and clear it.
- R10: Word address 4 returns the capability word CAP_WORD; writes to it have no effect. Unmapped addresses read zero.
- R11: Read data appears on `busRdata` at the clock edge of the read and holds its value until the next read.
- R12: A change of the enable bit before the previous latency has run out restarts the count, and idle then settles to the inverse of the final enable value with no intermediate change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busSel | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| enOut | output | 1 | Trace unit enable |
| pwrUpOut | output | 1 | Power-up request |
| idleOut | output | 1 | Unit idle status |

## Verification
The hardest state to reach from the ports is a configuration write that lands while the unit is disabled but not yet idle. The window only exists for IDLE_LAT cycles after a disable. The stimulus issues the configuration write on the cycle right after the disable and later reads the register back to show it kept its old value. A second hard case is an enable change in the middle of the drain window. The bench reverses the enable two cycles after the previous change, and then the idle flag is watched on every cycle against a behavioural model that restarts its count.

// File: rtl/trc_ctl_pkg.sv
`timescale 1ns/1ps
package trc_ctl_pkg;

  localparam int A_LOCK = 0;
  localparam int A_PROG = 1;
  localparam int A_STAT = 2;
  localparam int A_PWR  = 3;
  localparam int A_CAPS = 4;

  typedef enum logic [2:0] {
    RD_ZERO, RD_LOCK, RD_PROG, RD_STAT, RD_PWR, RD_CAPS, RD_CFG
  } rd_sel_e;

  typedef struct packed {
    logic    unlock;
    logic    progWr;
    logic    pwrWr;
    logic    cfgWr;
    logic    rdEn;
    rd_sel_e rdSel;
  } ctl_strobe_t;

endpackage

// File: rtl/trc_ctl_decode.sv
`timescale 1ns/1ps
module trc_ctl_decode
  import trc_ctl_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CFG_BASE = 8,
  parameter int NUM_CFG  = 4
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              osLock,
  input  logic              enState,
  input  logic              idleState,
  output ctl_strobe_t       strobe
);

  localparam int CFG_END = CFG_BASE + NUM_CFG;

  logic isCfg;
  logic cfgOpen;
  logic cfgVisible;

  always_comb begin
    isCfg      = (int'(busAddr) >= CFG_BASE) && (int'(busAddr) < CFG_END);
    cfgOpen    = !osLock && !enState && idleState;
    cfgVisible = !osLock && !enState;

    strobe       = '0;
    strobe.rdSel = RD_ZERO;

    if (busSel && busWrite) begin
      strobe.unlock = (busAddr == ADDR_W'(A_LOCK));
      strobe.progWr = (busAddr == ADDR_W'(A_PROG)) && !osLock;
      strobe.pwrWr  = (busAddr == ADDR_W'(A_PWR)) && !osLock;
      strobe.cfgWr  = isCfg && cfgOpen;
    end

    if (busSel && !busWrite) begin
      strobe.rdEn = 1'b1;
      if (busAddr == ADDR_W'(A_LOCK))      strobe.rdSel = RD_LOCK;
      else if (busAddr == ADDR_W'(A_PROG)) strobe.rdSel = RD_PROG;
      else if (busAddr == ADDR_W'(A_STAT)) strobe.rdSel = RD_STAT;
      else if (busAddr == ADDR_W'(A_PWR))  strobe.rdSel = RD_PWR;
      else if (busAddr == ADDR_W'(A_CAPS)) strobe.rdSel = RD_CAPS;
      else if (isCfg && cfgVisible)        strobe.rdSel = RD_CFG;
      else                                 strobe.rdSel = RD_ZERO;
    end
  end

endmodule

// File: rtl/trc_idle_seq.sv
`timescale 1ns/1ps
module trc_idle_seq #(
  parameter int IDLE_LAT = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic enChg,
  input  logic enNow,
  output logic idle
);

  localparam int CNT_W = $clog2(IDLE_LAT + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt  <= '0;
      idle <= 1'b1;
    end else if (enChg) begin
      cnt <= CNT_W'(IDLE_LAT);
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) idle <= !enNow;
    end
  end

endmodule

// File: rtl/trc_ctl_regs.sv
`timescale 1ns/1ps
module trc_ctl_regs
  import trc_ctl_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter int          CFG_BASE = 8,
  parameter int          NUM_CFG  = 4,
  parameter int          IDLE_LAT = 5,
  parameter logic [31:0] CAP_WORD = 32'h0A5C_0104
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic              osLock,
  output logic              enState,
  output logic              pwrState,
  output logic              idleState,
  output logic [31:0]       busRdata
);

  logic [31:0] cfgMem [NUM_CFG];
  logic [31:0] cfgRd;
  logic [31:0] rdMux;
  logic        enChg;

  assign enChg = strobe.progWr && (busWdata[0] != enState);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      osLock   <= 1'b1;
      enState  <= 1'b0;
      pwrState <= 1'b0;
    end else begin
      if (strobe.unlock) osLock   <= 1'b0;
      if (strobe.progWr) enState  <= busWdata[0];
      if (strobe.pwrWr)  pwrState <= busWdata[0];
    end
  end

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rstN)
        cfgMem[g] <= '0;
      else if (strobe.cfgWr && busAddr == ADDR_W'(CFG_BASE + g))
        cfgMem[g] <= busWdata;
    end
  end

  always_comb begin
    cfgRd = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (busAddr == ADDR_W'(CFG_BASE + i)) cfgRd = cfgMem[i];
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_LOCK: rdMux = {31'b0, osLock};
      RD_PROG: rdMux = {31'b0, enState};
      RD_STAT: rdMux = {30'b0, osLock, idleState};
      RD_PWR:  rdMux = {31'b0, pwrState};
      RD_CAPS: rdMux = CAP_WORD;
      RD_CFG:  rdMux = cfgRd;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            busRdata <= '0;
    else if (strobe.rdEn) busRdata <= rdMux;
  end

  trc_idle_seq #(.IDLE_LAT(IDLE_LAT)) i_idle (
    .clk   (clk),
    .rstN  (rstN),
    .enChg (enChg),
    .enNow (enState),
    .idle  (idleState)
  );

endmodule

// File: rtl/trace_prog_ctrl.sv
`timescale 1ns/1ps
module trace_prog_ctrl
  import trc_ctl_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter int          CFG_BASE = 8,
  parameter int          NUM_CFG  = 4,
  parameter int          IDLE_LAT = 5,
  parameter logic [31:0] CAP_WORD = 32'h0A5C_0104
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              enOut,
  output logic              pwrUpOut,
  output logic              idleOut
);

  ctl_strobe_t strobe;
  logic        osLock;

  trc_ctl_decode #(
    .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE), .NUM_CFG(NUM_CFG)
  ) i_decode (
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .osLock    (osLock),
    .enState   (enOut),
    .idleState (idleOut),
    .strobe    (strobe)
  );

  trc_ctl_regs #(
    .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE), .NUM_CFG(NUM_CFG),
    .IDLE_LAT(IDLE_LAT), .CAP_WORD(CAP_WORD)
  ) i_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .osLock    (osLock),
    .enState   (enOut),
    .pwrState  (pwrUpOut),
    .idleState (idleOut),
    .busRdata  (busRdata)
  );

endmodule

// File: rtl/trace_prog_ctrl_chk.sv
`timescale 1ns/1ps
module trace_prog_ctrl_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busRdata,
  input logic              enOut,
  input logic              pwrUpOut,
  input logic              idleOut,
  input logic              osLock
);

  // R5
  idle_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idleOut) |-> !enOut);

  // R6
  idle_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(idleOut) |-> enOut);

  // R4
  en_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enOut != $past(enOut)) |->
      $past(busSel && busWrite && busAddr == ADDR_W'(1) && !osLock));

  // R3
  pwr_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrUpOut != $past(pwrUpOut)) |->
      $past(busSel && busWrite && busAddr == ADDR_W'(3) && !osLock));

  // R2
  unlock_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(osLock) |-> $past(busSel && busWrite && busAddr == ADDR_W'(0)));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!(busSel && !busWrite)) |-> $stable(busRdata));

endmodule

bind trace_prog_ctrl trace_prog_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_trace_prog_ctrl.sv
`timescale 1ns/1ps
module test_trace_prog_ctrl;

  localparam int          L   = 5;
  localparam int          AW  = 4;
  localparam logic [31:0] CAP = 32'h0A5C_0104;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0;
  logic          busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic          enOut, pwrUpOut, idleOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  trace_prog_ctrl #(.ADDR_W(AW), .CFG_BASE(8), .NUM_CFG(4),
                    .IDLE_LAT(L), .CAP_WORD(CAP)) i_trace_prog_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .enOut(enOut), .pwrUpOut(pwrUpOut), .idleOut(idleOut));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  // Behavioural reference model
  bit          mLock, mEn, mPwr, mIdle, modelOn, enNew;
  int          mCnt;
  logic [31:0] mCfg [4];
  logic [31:0] mRd;
  int          a;

  always @(posedge clk) begin
    if (!rstN) begin
      mLock = 1; mEn = 0; mPwr = 0; mIdle = 1; mCnt = 0; mRd = '0;
      foreach (mCfg[i]) mCfg[i] = '0;
      modelOn = 1;
    end else begin
      a = int'(busAddr);
      if (busSel && !busWrite) begin
        if (a == 0)      mRd = {31'b0, mLock};
        else if (a == 1) mRd = {31'b0, mEn};
        else if (a == 2) mRd = {30'b0, mLock, mIdle};
        else if (a == 3) mRd = {31'b0, mPwr};
        else if (a == 4) mRd = CAP;
        else if (a >= 8 && a < 12) mRd = (mLock || mEn) ? 32'h0 : mCfg[a-8];
        else mRd = '0;
      end
      enNew = mEn;
      if (busSel && busWrite) begin
        if (a >= 8 && a < 12 && !mLock && !mEn && mIdle) mCfg[a-8] = busWdata;
        if (a == 1 && !mLock) enNew = busWdata[0];
        if (a == 3 && !mLock) mPwr = busWdata[0];
        if (a == 0) mLock = 0;
      end
      if (enNew != mEn) mCnt = L;
      else if (mCnt > 0) begin
        mCnt--;
        if (mCnt == 0) mIdle = !enNew;
      end
      mEn = enNew;
    end
  end

  always @(negedge clk) begin
    if (modelOn) begin
      chk("R4 enOut vs model", {31'b0, enOut}, {31'b0, mEn});
      chk("R9 pwrUpOut vs model", {31'b0, pwrUpOut}, {31'b0, mPwr});
      chk("R5 R6 R12 idleOut vs model", {31'b0, idleOut}, {31'b0, mIdle});
      chk("R11 busRdata vs model", busRdata, mRd);
    end
  end

  task automatic busWr(input int ad, input logic [31:0] d);
    busSel = 1; busWrite = 1; busAddr = AW'(ad); busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic busRd(input int ad, output logic [31:0] d);
    busSel = 1; busWrite = 0; busAddr = AW'(ad);
    @(negedge clk);
    busSel = 0;
    d = busRdata;
  endtask

  task automatic waitFlip(input string tag, input logic oldV);
    for (int k = 0; k < L; k++) begin
      chk(tag, {31'b0, idleOut}, {31'b0, oldV});
      @(negedge clk);
    end
    chk(tag, {31'b0, idleOut}, {31'b0, !oldV});
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 enOut", {31'b0, enOut}, 32'h0);
    chk("R1 pwrUpOut", {31'b0, pwrUpOut}, 32'h0);
    chk("R1 idleOut", {31'b0, idleOut}, 32'h1);
    busRd(0, rd); chk("R1 lock set", rd, 32'h1);

    // R3 locked writes ignored
    busWr(1, 32'h1); busWr(3, 32'h1); busWr(8, 32'hDEAD_BEEF);
    chk("R3 enable held", {31'b0, enOut}, 32'h0);
    chk("R3 power held", {31'b0, pwrUpOut}, 32'h0);
    busRd(8, rd); chk("R8 locked cfg read zero", rd, 32'h0);

    // R2 unlock with arbitrary data
    busWr(0, 32'h1234_5670);
    busRd(0, rd); chk("R2 lock cleared", rd, 32'h0);
    busRd(2, rd); chk("R2 status idle unlocked", rd, 32'h1);
    busRd(8, rd); chk("R3 cfg untouched while locked", rd, 32'h0);

    // R7 configuration while disabled and idle
    for (int i = 0; i < 4; i++) busWr(8 + i, 32'hA000_0000 + 32'(i * 17));
    for (int i = 0; i < 4; i++) begin
      busRd(8 + i, rd); chk("R7 cfg stored", rd, 32'hA000_0000 + 32'(i * 17));
    end

    // R10 capability word
    busRd(4, rd); chk("R10 caps", rd, CAP);
    busWr(4, 32'h0); busRd(4, rd); chk("R10 caps write ignored", rd, CAP);
    busRd(13, rd); chk("R10 unmapped zero", rd, 32'h0);

    // R9 power-up request
    busWr(3, 32'h1); chk("R9 power set", {31'b0, pwrUpOut}, 32'h1);

    // R4 R6 enable and idle fall
    busWr(1, 32'h1);
    chk("R4 enable set", {31'b0, enOut}, 32'h1);
    waitFlip("R6 idle fall latency", 1'b1);
    busRd(9, rd); chk("R8 enabled cfg read zero", rd, 32'h0);
    busWr(9, 32'h1111_1111);

    // R5 disable and idle rise
    busWr(1, 32'h0);
    waitFlip("R5 idle rise latency", 1'b0);
    busRd(9, rd); chk("R7 write while enabled dropped", rd, 32'hA000_0011);

    // R7 write during drain window
    busWr(1, 32'h1);
    repeat (L + 1) @(negedge clk);
    busWr(1, 32'h0);
    busWr(10, 32'h5555_5555);
    chk("R7 still draining", {31'b0, idleOut}, 32'h0);
    repeat (L + 1) @(negedge clk);
    busRd(10, rd); chk("R7 write while draining dropped", rd, 32'hA000_0022);

    // R12 reversal mid-window (enabled, idle low)
    busWr(1, 32'h1);
    repeat (L + 1) @(negedge clk);
    busWr(1, 32'h0);
    @(negedge clk);
    busWr(1, 32'h1);
    for (int k = 0; k < L + 3; k++) begin
      chk("R12 idle stays low", {31'b0, idleOut}, 32'h0);
      @(negedge clk);
    end
    busWr(1, 32'h0);
    repeat (L + 1) @(negedge clk);
    chk("R12 idle settles high", {31'b0, idleOut}, 32'h1);

    // R9 clear power, R11 hold
    busWr(3, 32'h0); chk("R9 power cleared", {31'b0, pwrUpOut}, 32'h0);
    busRd(4, rd);
    repeat (3) @(negedge clk);
    chk("R11 rdata held", busRdata, CAP);

    // R1 reset mid-run relocks
    rstN = 0; repeat (2) @(negedge clk); rstN = 1; @(negedge clk);
    busRd(0, rd); chk("R1 relocked after reset", rd, 32'h1);
    busRd(8, rd); chk("R1 cfg cleared (locked read)", rd, 32'h0);
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule